// File: doc/BRIEF.md
# Message Checksum and Header Monitor

This block sits beside the receive path of a serial-bus terminal and watches the data words of each message as they go by. It marks the first data word of every message as the header word. It folds each enabled data word into a running checksum. When the last word of the message arrives, it decides whether that checksum is valid.

The verdict is shown in two forms. The first is a raw status line. It flips on every data word while checking is enabled, and it settles on the verdict at the last word. The second is a latched flag with the opposite sense. The latched flag is captured on the falling edge of a strobe. In terminal mode that strobe is the command-word strobe, and in controller mode it is the status-word strobe. Between those edges the flag holds its value, so a host can read the result of the previous message while the next one is running.

The checksum rotates each word left by its position in the message, taken modulo 16. It XORs the rotated words together. A message is valid when the result is zero after the last word. A command strobe starts a new message.

Top module: `msg_chk_monitor`

## Requirements
- R1: During and after synchronous reset, `chk_status` is 1, `chk_bad_q` is 0 and `hdr_n` is 1.
- R2: `hdr_n` is 0, combinationally, while `word_vld` is 1 for the first data word after a cycle with `cmd_stb` high. It is 1 for every other word and whenever `word_vld` is 0. This holds whether checking is enabled or not.
- R3: While `chk_en_n` is 0, each accepted word with `word_last` = 0 inverts `chk_status` on the next clock edge. In a cycle with no accepted word, `chk_status` keeps its value.
- R4: The word with position k (counted from 0 over enabled words since message start) is rotated left by k mod 16 bits and XORed into an accumulator. At a word with `word_last` = 1, `chk_status` becomes 1 if the new accumulator is zero and 0 otherwise. Position 16 and beyond wrap the rotation amount.
- R5: While `chk_en_n` is 1, `chk_status` is forced to 1. Words neither change the accumulator nor advance the position. The message continues from where it was once checking is enabled again.
- R6: A cycle with `cmd_stb` high clears the accumulator and the position, and re-arms the header flag, without changing `chk_status`.
- R7: With `ctrl_mode` = 0, a falling edge of `cmd_stb` loads `chk_bad_q` with the inverse of `chk_status`, as it stood before that edge. Here 0 means valid and 1 means not valid.
- R8: With `ctrl_mode` = 1, a falling edge of `sts_stb` loads `chk_bad_q` in the same way, and falling edges of `cmd_stb` leave it unchanged.
- R9: Without a falling edge of the selected strobe, `chk_bad_q` keeps its value, even across a complete message.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| chk_en_n | input | 1 | Checksum enable, active low |
| ctrl_mode | input | 1 | 0 = terminal mode, 1 = controller mode |
| cmd_stb | input | 1 | Command-word strobe; high starts a message |
| sts_stb | input | 1 | Status-word strobe |
| word_vld | input | 1 | Data word valid this cycle |
| word_data | input | 16 | Received data word |
| word_last | input | 1 | Marks the last data word of the message |
| hdr_n | output | 1 | Header word present, active low |
| chk_status | output | 1 | Raw running checksum status line |
| chk_bad_q | output | 1 | Latched verdict: 0 valid, 1 not valid |

## Verification
The assertions assume that the strobes, the enable and the mode are plain levels sampled once per clock. They assume that `word_last` has meaning only when `word_vld` is high. They also assume that `cmd_stb` and a data word do not share a cycle. The bench therefore drives every input just after the falling clock edge. It keeps each strobe pulse one cycle wide and separate from data words. It raises `word_last` only together with `word_vld`. It changes the mode only while both strobes are low.

// File: rtl/msg_chk_pkg.sv
package msg_chk_pkg;

    localparam int WORD_W = 16;
    localparam int IDX_W  = 6;
    localparam int ROT_W  = $clog2(WORD_W);

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [IDX_W-1:0]  idx_t;

    typedef enum logic {
        MODE_TERM = 1'b0,
        MODE_CTRL = 1'b1
    } mode_e;

    typedef struct packed {
        logic  vld;
        logic  last;
        word_t data;
    } word_in_s;

    typedef struct packed {
        word_t acc;
        idx_t  idx;
        logic  first;
    } accum_s;

    localparam accum_s ACCUM_CLEAR = '{acc: '0, idx: '0, first: 1'b1};

    function automatic word_t rotl(input word_t w, input idx_t amt);
        word_t r;
        int unsigned sh;
        sh = int'(amt) % WORD_W;
        for (int i = 0; i < WORD_W; i++) begin
            r[(i + sh) % WORD_W] = w[i];
        end
        return r;
    endfunction

endpackage

// File: rtl/msg_chk_fall_det.sv
module msg_chk_fall_det (
    input  logic clk,
    input  logic rst,
    input  logic lvl,
    output logic fall
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= lvl;
    end

    assign fall = prev_q & ~lvl;
endmodule

// File: rtl/msg_chk_accum.sv
module msg_chk_accum
    import msg_chk_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     en,
    input  logic     start,
    input  word_in_s win,
    output word_t    acc_next,
    output logic     first_now
);
    accum_s st_q, base, nxt;

    always_comb begin
        base = start ? ACCUM_CLEAR : st_q;
        nxt  = base;
        if (win.vld) begin
            nxt.first = 1'b0;
            if (en) begin
                nxt.acc = base.acc ^ rotl(win.data, base.idx);
                nxt.idx = base.idx + idx_t'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= ACCUM_CLEAR;
        else     st_q <= nxt;
    end

    assign acc_next  = nxt.acc;
    assign first_now = base.first;
endmodule

// File: rtl/msg_chk_verdict.sv
module msg_chk_verdict
    import msg_chk_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  en,
    input  logic  vld,
    input  logic  last,
    input  word_t acc_next,
    input  logic  latch_fall,
    output logic  status,
    output logic  bad_q
);
    logic status_q, bad_r;

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= 1'b1;
        end else if (!en) begin
            status_q <= 1'b1;
        end else if (vld) begin
            status_q <= last ? (acc_next == '0) : ~status_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)             bad_r <= 1'b0;
        else if (latch_fall) bad_r <= ~status_q;
    end

    assign status = status_q;
    assign bad_q  = bad_r;
endmodule

// File: rtl/msg_chk_monitor.sv
module msg_chk_monitor
    import msg_chk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              chk_en_n,
    input  logic              ctrl_mode,
    input  logic              cmd_stb,
    input  logic              sts_stb,
    input  logic              word_vld,
    input  logic [WORD_W-1:0] word_data,
    input  logic              word_last,
    output logic              hdr_n,
    output logic              chk_status,
    output logic              chk_bad_q
);
    localparam int N_STB = 2;

    logic             en;
    mode_e            mode;
    word_in_s         win;
    word_t            acc_next;
    logic             first_now;
    logic [N_STB-1:0] stb_lvl, stb_fall;
    logic             latch_fall;

    assign en      = ~chk_en_n;
    assign mode    = mode_e'(ctrl_mode);
    assign win     = '{vld: word_vld, last: word_last, data: word_data};
    assign stb_lvl = {sts_stb, cmd_stb};

    for (genvar g = 0; g < N_STB; g++) begin : g_edge
        msg_chk_fall_det u_fall (
            .clk  (clk),
            .rst  (rst),
            .lvl  (stb_lvl[g]),
            .fall (stb_fall[g])
        );
    end

    assign latch_fall = (mode == MODE_CTRL) ? stb_fall[1] : stb_fall[0];

    msg_chk_accum u_accum (
        .clk       (clk),
        .rst       (rst),
        .en        (en),
        .start     (cmd_stb),
        .win       (win),
        .acc_next  (acc_next),
        .first_now (first_now)
    );

    msg_chk_verdict u_verdict (
        .clk        (clk),
        .rst        (rst),
        .en         (en),
        .vld        (word_vld),
        .last       (word_last),
        .acc_next   (acc_next),
        .latch_fall (latch_fall),
        .status     (chk_status),
        .bad_q      (chk_bad_q)
    );

    assign hdr_n = ~(word_vld & first_now);
endmodule

// File: rtl/msg_chk_monitor_sva.sv
module msg_chk_monitor_sva (
    input logic clk,
    input logic rst,
    input logic chk_en_n,
    input logic ctrl_mode,
    input logic cmd_stb,
    input logic sts_stb,
    input logic word_vld,
    input logic word_last,
    input logic hdr_n,
    input logic chk_status,
    input logic chk_bad_q
);
    logic cmd_prev, sts_prev, sel_fall;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_prev <= 1'b0;
            sts_prev <= 1'b0;
        end else begin
            cmd_prev <= cmd_stb;
            sts_prev <= sts_stb;
        end
    end

    assign sel_fall = ctrl_mode ? (sts_prev & ~sts_stb) : (cmd_prev & ~cmd_stb);

    // R1
    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (chk_status && !chk_bad_q));

    // R2
    p_hdr_needs_word_r2: assert property (@(posedge clk) disable iff (rst)
        !hdr_n |-> word_vld);

    // R3
    p_toggle_r3: assert property (@(posedge clk) disable iff (rst)
        (!chk_en_n && word_vld && !word_last) |=> (chk_status != $past(chk_status)));

    // R3
    p_idle_stable_r3: assert property (@(posedge clk) disable iff (rst)
        (!chk_en_n && !word_vld) |=> $stable(chk_status));

    // R5
    p_disabled_valid_r5: assert property (@(posedge clk) disable iff (rst)
        chk_en_n |=> chk_status);

    // R7 / R8
    p_latch_value_r7: assert property (@(posedge clk) disable iff (rst)
        sel_fall |=> (chk_bad_q == !$past(chk_status)));

    // R9
    p_latch_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !sel_fall |=> $stable(chk_bad_q));
endmodule

bind msg_chk_monitor msg_chk_monitor_sva u_sva (
    .clk        (clk),
    .rst        (rst),
    .chk_en_n   (chk_en_n),
    .ctrl_mode  (ctrl_mode),
    .cmd_stb    (cmd_stb),
    .sts_stb    (sts_stb),
    .word_vld   (word_vld),
    .word_last  (word_last),
    .hdr_n      (hdr_n),
    .chk_status (chk_status),
    .chk_bad_q  (chk_bad_q)
);

// File: tb/test_msg_chk_monitor.sv
module test_msg_chk_monitor;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        chk_en_n = 1'b0;
    logic        ctrl_mode = 1'b0;
    logic        cmd_stb = 1'b0;
    logic        sts_stb = 1'b0;
    logic        word_vld = 1'b0;
    logic [15:0] word_data = '0;
    logic        word_last = 1'b0;
    logic        hdr_n, chk_status, chk_bad_q;

    int nvec = 0;
    int nbad = 0;

    logic [15:0] m_acc;
    int          m_idx;
    bit          m_status;
    bit          m_bad;

    always #5 clk = ~clk;

    msg_chk_monitor i_msg_chk_monitor (
        .clk(clk), .rst(rst), .chk_en_n(chk_en_n), .ctrl_mode(ctrl_mode),
        .cmd_stb(cmd_stb), .sts_stb(sts_stb), .word_vld(word_vld),
        .word_data(word_data), .word_last(word_last), .hdr_n(hdr_n),
        .chk_status(chk_status), .chk_bad_q(chk_bad_q)
    );

    function automatic logic [15:0] rl(logic [15:0] w, int k);
        int s = k % 16;
        return (s == 0) ? w : ((w << s) | (w >> (16 - s)));
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        nvec++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle();
        @(negedge clk);
        word_vld = 0; word_last = 0; cmd_stb = 0; sts_stb = 0;
    endtask

    task automatic pulse_cmd();
        @(negedge clk);
        word_vld = 0; cmd_stb = 1;
        @(negedge clk);
        cmd_stb = 0;
        m_acc = '0; m_idx = 0;
        if (!ctrl_mode) m_bad = !m_status;
        @(negedge clk);
        chk(chk_bad_q == m_bad, ctrl_mode ? "R8 cmd edge ignored" : "R7 latch on cmd fall",
            chk_bad_q, m_bad);
    endtask

    task automatic pulse_sts();
        @(negedge clk);
        sts_stb = 1;
        @(negedge clk);
        sts_stb = 0;
        if (ctrl_mode) m_bad = !m_status;
        @(negedge clk);
        chk(chk_bad_q == m_bad, "R8 latch on sts fall", chk_bad_q, m_bad);
    endtask

    // one word, with header and status checks
    task automatic put_word(logic [15:0] w, bit last, bit exp_hdr, bit check_hdr);
        @(negedge clk);
        word_vld = 1; word_data = w; word_last = last;
        #1;
        if (check_hdr) chk(hdr_n == !exp_hdr, "R2 header flag", hdr_n, !exp_hdr);
        if (!chk_en_n) begin
            m_acc = m_acc ^ rl(w, m_idx);
            m_idx++;
            m_status = last ? (m_acc == 0) : !m_status;
        end else begin
            m_status = 1;
        end
        @(negedge clk);
        word_vld = 0; word_last = 0;
        chk(hdr_n == 1, "R2 header idle", hdr_n, 1);
        chk(chk_status == m_status, last ? "R4 verdict" : "R3 toggle", chk_status, m_status);
    endtask

    task automatic send_msg(int n, bit good, int seed);
        logic [15:0] w;
        pulse_cmd();
        for (int k = 0; k < n - 1; k++) begin
            w = 16'(seed * 977 + k * 4099 + 16'h1357);
            put_word(w, 0, k == 0, 1);
        end
        w = rl(m_acc, 16 - ((m_idx) % 16));
        if (!good) w = w ^ 16'h0100;
        put_word(w, 1, n == 1, 1);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(chk_status == 1, "R1 status", chk_status, 1);
        chk(chk_bad_q == 0, "R1 latched", chk_bad_q, 0);
        chk(hdr_n == 1, "R1 header", hdr_n, 1);
        rst = 0;
        m_acc = 0; m_idx = 0; m_status = 1; m_bad = 0;
        idle();
        chk(chk_status == 1 && chk_bad_q == 0, "R1 after release", chk_status, 1);
    endtask

    task automatic t_term_bad_then_good();
        send_msg(4, 0, 3);
        pulse_cmd();
        chk(chk_bad_q == 1, "R7 bad latched", chk_bad_q, 1);
        send_msg(5, 1, 8);
        pulse_cmd();
        chk(chk_bad_q == 0, "R7 good latched", chk_bad_q, 0);
    endtask

    task automatic t_idle_stable();
        logic s;
        s = chk_status;
        repeat (3) idle();
        chk(chk_status == s, "R3 no word no change", chk_status, s);
    endtask

    task automatic t_wrap();
        send_msg(20, 1, 21);
        send_msg(19, 0, 5);
        send_msg(1, 1, 0);
    endtask

    task automatic t_restart();
        pulse_cmd();
        put_word(16'hBEEF, 0, 1, 1);
        put_word(16'h1234, 0, 0, 1);
        send_msg(3, 1, 11);
        chk(chk_status == 1, "R6 restart clears sum", chk_status, 1);
    endtask

    task automatic t_disabled();
        pulse_cmd();
        put_word(16'hA5C3, 0, 1, 1);
        @(negedge clk); chk_en_n = 1;
        @(negedge clk);
        chk(chk_status == 1, "R5 forced valid", chk_status, 1);
        put_word(16'h0F0F, 0, 0, 1);
        put_word(16'h7777, 1, 0, 1);
        chk(chk_status == 1, "R5 disabled last", chk_status, 1);
        @(negedge clk); chk_en_n = 0;
        put_word(rl(m_acc, 15), 1, 0, 1);
        chk(chk_status == 1, "R5 words skipped", chk_status, 1);
        // header flagged while disabled
        @(negedge clk); chk_en_n = 1;
        pulse_cmd();
        put_word(16'h0001, 0, 1, 1);
        @(negedge clk); chk_en_n = 0;
    endtask

    task automatic t_ctrl_mode();
        send_msg(3, 0, 2);
        @(negedge clk); ctrl_mode = 1;
        pulse_cmd();
        chk(chk_bad_q == 0, "R8 cmd ignored", chk_bad_q, 0);
        pulse_sts();
        chk(chk_bad_q == 1, "R8 sts latched", chk_bad_q, 1);
        send_msg(4, 1, 6);
        chk(chk_bad_q == 1, "R9 hold across message", chk_bad_q, 1);
        pulse_sts();
        chk(chk_bad_q == 0, "R8 sts good", chk_bad_q, 0);
        @(negedge clk); ctrl_mode = 0;
    endtask

    task automatic t_hold_term();
        send_msg(2, 0, 9);
        chk(chk_bad_q == 0, "R9 no edge no change", chk_bad_q, 0);
        pulse_sts();
        chk(chk_bad_q == 0, "R9 sts ignored in terminal", chk_bad_q, 0);
        pulse_cmd();
        chk(chk_bad_q == 1, "R7 latched after hold", chk_bad_q, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_term_bad_then_good();
        t_idle_stable();
        t_wrap();
        t_restart();
        t_disabled();
        t_ctrl_mode();
        t_hold_term();
        repeat (2) idle();
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        nvec++; nbad++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end
endmodule